// File: doc/BRIEF.md
# Batched Column Matrix-Vector Engine

This engine works through one model column at a time. A column holds 40 vertical levels, and each level carries its own small, independent matrix-vector product. At level k, output df is the sum over j of x[j][k] * M[k][j][df], with df running over 8 outputs and j over 6 inputs. Every level has its own matrix. Operands are signed 16-bit integers, and each result is kept at the full 40-bit accumulator width with no saturation.

The matrix, the input vectors and the results live in on-chip memories. All three use the level index k as the fastest-varying address bit. The matrix is stored transposed, so every sweep the engine makes reads and writes sequentially in k. The host owns a simple word-wide memory port. It loads x and M while the engine is idle, pulses `start`, polls `idle` until it returns high, and then reads the results out.

Inside, the level loop is the innermost loop and runs one level per clock. The input index is the middle loop and the output index is the outer loop. A bank of 40 running-sum registers, one per level, holds the partial sums between passes, so the result memory is written once per entry and never read back during a run.

The controller is a three-state machine:
- **IDLE**: `idle` is high and the host port is live. IDLE goes to RUN when `start` is seen.
- **RUN**: one multiply-accumulate address is issued per cycle. RUN goes to DRAIN after the last address has been issued.
- **DRAIN**: the pipeline empties. DRAIN goes to IDLE on the clock edge that commits the final result.

Top module: `cmv_top`

## Requirements
- R1: After a run, result entry (df,k) equals the sum over j=0..5 of x[j][k]*M[k][j][df], for all 8 outputs and all 40 levels.
- R2: Each result starts its sum from zero. Values left over from earlier runs or from other outputs never leak into a new result.
- R3: Products and sums are signed and carried at 40 bits. A result such as 6*(-32768)*(-32768) = 6442450944 reads back exactly, with no truncation or saturation.
- R4: The memories are selected by `host_sel`: 0 is x, 1 is M, 2 is the results. Addresses are j*40+k for x, (df*6+j)*40+k for M, and df*40+k for the results.
- R5: `idle` is 1 after reset. `start` is accepted only while `idle` is 1, and `idle` reads 0 from the clock edge that accepts `start` onward.
- R6: `idle` stays low for exactly 8*6*40+1 = 1921 clock edges after the accepting edge. Every result is in memory by the edge at which `idle` returns high.
- R7: Host writes to x or M made while `idle` is 0 are ignored. Neither the results of that run nor the stored value change.
- R8: A `start` pulse during a run is ignored. The run length and the results stay the same.
- R9: A host read returns data one clock after the address is presented. x and M values come back sign-extended to 40 bits. A read made while busy returns 0, and so does the read output after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled only while idle |
| idle | output | 1 | High when the engine is idle and the host port is live |
| host_we | input | 1 | Host write enable, for x and M only |
| host_sel | input | 2 | Memory select: 0 is x, 1 is M, 2 is results |
| host_addr | input | 11 | Word address within the selected memory |
| host_wdata | input | 16 | Signed write data |
| host_rdata | output | 40 | Signed read data, valid one cycle after the address |

## Verification
The bench drives the engine with extreme operands whose sum of six products does not fit in 32 bits. A design that narrowed or saturated the accumulator would return wrong values there. Back-to-back runs use different data, so a design that failed to clear its running sums would carry the previous column's values into the next. During one run the bench also writes into x, pulses `start` again and reads the result memory. A design that let any of these through would corrupt the results, restart the run and change its length, or return nonzero read data. Exact idle-to-idle cycle counting catches a pipeline that drops or adds a stage, and reading every result entry catches any error in the transposed addressing.

// File: rtl/cmv_pkg.sv
package cmv_pkg;
    typedef enum logic [1:0] {
        SEL_X   = 2'd0,
        SEL_M   = 2'd1,
        SEL_LHS = 2'd2
    } mem_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_e;
endpackage

// File: rtl/cmv_ram.sv
module cmv_ram #(
    parameter int DEPTH = 240,
    parameter int W     = 16,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && int'(waddr) < DEPTH)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/cmv_ctrl.sv
module cmv_ctrl
    import cmv_pkg::*;
#(
    parameter int NOUT  = 8,
    parameter int NIN   = 6,
    parameter int NLEV  = 40,
    parameter int ADDRW = 11,
    parameter int KW    = $clog2(NLEV),
    parameter int JW    = $clog2(NIN),
    parameter int FW    = $clog2(NOUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             commit_last,
    output logic             idle,
    output logic             iss_vld,
    output logic             iss_first,
    output logic             iss_lastj,
    output logic             iss_final,
    output logic [KW-1:0]    iss_k,
    output logic [FW-1:0]    iss_df,
    output logic [ADDRW-1:0] x_raddr,
    output logic [ADDRW-1:0] m_raddr
);
    localparam int TOTAL = NOUT * NIN * NLEV;

    run_state_e state, state_nx;
    logic [KW-1:0] k_q;
    logic [JW-1:0] j_q;
    logic [FW-1:0] df_q;
    int unsigned   run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        idle      = 1'b0;
        iss_vld   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle = 1'b1;
                if (start) state_nx = ST_RUN;
            end
            ST_RUN: begin
                iss_vld = 1'b1;
                if (iss_final) state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (commit_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // level innermost, input index middle, output index outer
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) begin
            k_q  <= '0;
            j_q  <= '0;
            df_q <= '0;
        end else if (iss_vld) begin
            if (k_q == KW'(NLEV - 1)) begin
                k_q <= '0;
                if (j_q == JW'(NIN - 1)) begin
                    j_q  <= '0;
                    df_q <= df_q + 1'b1;
                end else begin
                    j_q <= j_q + 1'b1;
                end
            end else begin
                k_q <= k_q + 1'b1;
            end
        end
    end

    assign iss_first = (j_q == '0);
    assign iss_lastj = (j_q == JW'(NIN - 1));
    assign iss_final = iss_vld && iss_lastj && (k_q == KW'(NLEV - 1))
                       && (df_q == FW'(NOUT - 1));
    assign iss_k     = k_q;
    assign iss_df    = df_q;
    assign x_raddr   = ADDRW'(int'(j_q) * NLEV + int'(k_q));
    assign m_raddr   = ADDRW'((int'(df_q) * NIN + int'(j_q)) * NLEV + int'(k_q));

    always_ff @(posedge clk) begin
        if (!rst_n || idle) run_cnt <= 0;
        else                run_cnt <= run_cnt + 1;
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> !idle);                                   // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && start && !commit_last) |=> !idle);                  // R8
    AST_IDLE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_last |=> idle);                                        // R6
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        commit_last |-> run_cnt == TOTAL);                            // R6
endmodule

// File: rtl/cmv_mac.sv
module cmv_mac #(
    parameter int NLEV  = 40,
    parameter int DW    = 16,
    parameter int ACCW  = 40,
    parameter int ADDRW = 11,
    parameter int KW    = 6,
    parameter int FW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_vld,
    input  logic             iss_first,
    input  logic             iss_lastj,
    input  logic             iss_final,
    input  logic [KW-1:0]    iss_k,
    input  logic [FW-1:0]    iss_df,
    input  logic [DW-1:0]    x_q,
    input  logic [DW-1:0]    m_q,
    output logic             wr_en,
    output logic [ADDRW-1:0] wr_addr,
    output logic [ACCW-1:0]  wr_data,
    output logic             commit_last
);
    localparam int PW = 2 * DW;

    logic             s_vld, s_first, s_lastj, s_final;
    logic [KW-1:0]    s_k;
    logic [FW-1:0]    s_df;
    logic signed [ACCW-1:0] acc [NLEV];
    logic signed [PW-1:0]   prod;
    logic signed [ACCW-1:0] base, sum;

    // stage aligned with the registered memory read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vld   <= 1'b0;
            s_first <= 1'b0;
            s_lastj <= 1'b0;
            s_final <= 1'b0;
            s_k     <= '0;
            s_df    <= '0;
        end else begin
            s_vld   <= iss_vld;
            s_first <= iss_first;
            s_lastj <= iss_lastj;
            s_final <= iss_final;
            s_k     <= iss_k;
            s_df    <= iss_df;
        end
    end

    always_comb begin
        prod = $signed(x_q) * $signed(m_q);
        base = s_first ? '0 : acc[s_k];
        sum  = base + {{(ACCW - PW){prod[PW-1]}}, prod};
    end

    always_ff @(posedge clk) begin
        if (s_vld) acc[s_k] <= sum;
    end

    assign wr_en       = s_vld && s_lastj;
    assign wr_addr     = ADDRW'(int'(s_df) * NLEV + int'(s_k));
    assign wr_data     = sum;
    assign commit_last = s_vld && s_final;

    AST_K_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (s_vld && $past(s_vld)) |->
        s_k == (($past(s_k) == KW'(NLEV - 1)) ? '0 : $past(s_k) + 1'b1)); // R6
endmodule

// File: rtl/cmv_top.sv
module cmv_top
    import cmv_pkg::*;
#(
    parameter int NOUT  = 8,
    parameter int NIN   = 6,
    parameter int NLEV  = 40,
    parameter int DW    = 16,
    parameter int ACCW  = 40,
    parameter int ADDRW = $clog2(NOUT * NIN * NLEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             idle,
    input  logic             host_we,
    input  logic [1:0]       host_sel,
    input  logic [ADDRW-1:0] host_addr,
    input  logic [DW-1:0]    host_wdata,
    output logic [ACCW-1:0]  host_rdata
);
    localparam int KW     = $clog2(NLEV);
    localparam int FW     = $clog2(NOUT);
    localparam int X_DEP  = NIN * NLEV;
    localparam int M_DEP  = NOUT * NIN * NLEV;
    localparam int L_DEP  = NOUT * NLEV;

    logic             iss_vld, iss_first, iss_lastj, iss_final, commit_last;
    logic [KW-1:0]    iss_k;
    logic [FW-1:0]    iss_df;
    logic [ADDRW-1:0] x_eaddr, m_eaddr, x_ra, m_ra, lhs_wa;
    logic [DW-1:0]    x_q, m_q;
    logic [ACCW-1:0]  lhs_q, lhs_wd;
    logic             lhs_we, x_we, m_we;
    logic [1:0]       rsel_q;
    logic             rbusy_q;

    cmv_ctrl #(.NOUT(NOUT), .NIN(NIN), .NLEV(NLEV), .ADDRW(ADDRW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .commit_last(commit_last),
        .idle(idle), .iss_vld(iss_vld), .iss_first(iss_first),
        .iss_lastj(iss_lastj), .iss_final(iss_final), .iss_k(iss_k),
        .iss_df(iss_df), .x_raddr(x_eaddr), .m_raddr(m_eaddr)
    );

    assign x_we = host_we && idle && (host_sel == SEL_X);
    assign m_we = host_we && idle && (host_sel == SEL_M);
    assign x_ra = idle ? host_addr : x_eaddr;
    assign m_ra = idle ? host_addr : m_eaddr;

    cmv_ram #(.DEPTH(X_DEP), .W(DW), .AW(ADDRW)) u_xmem (
        .clk(clk), .we(x_we), .waddr(host_addr), .wdata(host_wdata),
        .raddr(x_ra), .rdata(x_q)
    );
    cmv_ram #(.DEPTH(M_DEP), .W(DW), .AW(ADDRW)) u_mmem (
        .clk(clk), .we(m_we), .waddr(host_addr), .wdata(host_wdata),
        .raddr(m_ra), .rdata(m_q)
    );
    cmv_ram #(.DEPTH(L_DEP), .W(ACCW), .AW(ADDRW)) u_lmem (
        .clk(clk), .we(lhs_we), .waddr(lhs_wa), .wdata(lhs_wd),
        .raddr(host_addr), .rdata(lhs_q)
    );

    cmv_mac #(.NLEV(NLEV), .DW(DW), .ACCW(ACCW), .ADDRW(ADDRW), .KW(KW), .FW(FW)) u_mac (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_first(iss_first),
        .iss_lastj(iss_lastj), .iss_final(iss_final), .iss_k(iss_k),
        .iss_df(iss_df), .x_q(x_q), .m_q(m_q), .wr_en(lhs_we),
        .wr_addr(lhs_wa), .wr_data(lhs_wd), .commit_last(commit_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel_q  <= '0;
            rbusy_q <= 1'b1;
        end else begin
            rsel_q  <= host_sel;
            rbusy_q <= !idle;
        end
    end

    always_comb begin
        if (rbusy_q)
            host_rdata = '0;
        else if (rsel_q == SEL_LHS)
            host_rdata = lhs_q;
        else if (rsel_q == SEL_M)
            host_rdata = {{(ACCW - DW){m_q[DW-1]}}, m_q};
        else
            host_rdata = {{(ACCW - DW){x_q[DW-1]}}, x_q};
    end

    AST_LHS_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        lhs_we |-> !idle);                                            // R6
endmodule

// File: tb/sim_cmv_top.sv
module sim_cmv_top;
    localparam int NOUT = 8, NIN = 6, NLEV = 40, ADDRW = 11;

    logic        clk = 0, rst_n = 0, start = 0, host_we = 0;
    logic [1:0]  host_sel = 0;
    logic [ADDRW-1:0] host_addr = 0;
    logic [15:0] host_wdata = 0;
    logic [39:0] host_rdata;
    logic        idle;

    int n_chk = 0, n_fail = 0;
    shortint bx [NIN][NLEV];
    shortint bm [NOUT][NIN][NLEV];

    always #2 clk = ~clk;

    cmv_top u0 (.clk(clk), .rst_n(rst_n), .start(start), .idle(idle),
                .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
                .host_wdata(host_wdata), .host_rdata(host_rdata));

    function automatic longint ref_lhs(int df, int k);
        longint s = 0;
        for (int j = 0; j < NIN; j++) s += longint'(bx[j][k]) * longint'(bm[df][j][k]);
        return s;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, int a, logic [15:0] d);
        @(negedge clk);
        host_we = 1; host_sel = s; host_addr = ADDRW'(a); host_wdata = d;
        @(posedge clk); #1 host_we = 0;
    endtask

    task automatic rd(logic [1:0] s, int a, output longint v);
        @(negedge clk);
        host_we = 0; host_sel = s; host_addr = ADDRW'(a);
        @(posedge clk); @(negedge clk);
        v = longint'($signed(host_rdata));
    endtask

    // R4: x at j*40+k (sel 0), M at (df*6+j)*40+k (sel 1)
    task automatic load_all();
        for (int j = 0; j < NIN; j++)
            for (int k = 0; k < NLEV; k++) wr(2'd0, j*NLEV + k, bx[j][k]);
        for (int df = 0; df < NOUT; df++)
            for (int j = 0; j < NIN; j++)
                for (int k = 0; k < NLEV; k++)
                    wr(2'd1, (df*NIN + j)*NLEV + k, bm[df][j][k]);
    endtask

    task automatic run(bit disturb, string len_req);
        int cnt = 0;
        @(negedge clk); start = 1;
        @(posedge clk); #1 start = 0;
        chk(idle == 0, "R5 idle low after start", idle, 0);
        do begin
            @(posedge clk); #1; cnt++;
            if (disturb) begin
                if (cnt == 100) begin host_we = 1; host_sel = 2'd0; host_addr = 0; host_wdata = 16'h1234; end
                if (cnt == 101) host_we = 0;
                if (cnt == 200) start = 1;
                if (cnt == 201) start = 0;
                if (cnt == 300) begin host_sel = 2'd2; host_addr = 0; end
                if (cnt == 301) chk(host_rdata == 0, "R9 read while busy", longint'($signed(host_rdata)), 0);
            end
        end while (!idle && cnt < 5000);
        chk(cnt == 1921, len_req, cnt, 1921);
    endtask

    task automatic verify(string req);
        longint v;
        for (int df = 0; df < NOUT; df++)
            for (int k = 0; k < NLEV; k++) begin
                rd(2'd2, df*NLEV + k, v);   // R4: results at df*40+k, sel 2
                chk(v == ref_lhs(df, k), req, v, ref_lhs(df, k));
            end
    endtask

    task automatic fill_random(int zero_pct);
        for (int j = 0; j < NIN; j++)
            for (int k = 0; k < NLEV; k++)
                bx[j][k] = ($urandom % 100 < zero_pct) ? 16'sd0 : shortint'($urandom);
        for (int df = 0; df < NOUT; df++)
            for (int j = 0; j < NIN; j++)
                for (int k = 0; k < NLEV; k++)
                    bm[df][j][k] = shortint'($urandom);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        longint v;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(idle == 1, "R5 idle after reset", idle, 1);
        chk(host_rdata == 0, "R9 rdata after reset", longint'($signed(host_rdata)), 0);

        // R1: random column
        fill_random(0);
        load_all();
        run(0, "R6 run length");
        verify("R1 result mismatch");
        rd(2'd0, 3*NLEV + 7, v);
        chk(v == bx[3][7], "R9 x readback sign-extended", v, bx[3][7]);
        rd(2'd1, (5*NIN + 2)*NLEV + 39, v);
        chk(v == bm[5][2][39], "R4 M readback address", v, bm[5][2][39]);

        // R3: extreme operands, sums beyond 32 bits
        for (int j = 0; j < NIN; j++)
            for (int k = 0; k < NLEV; k++) bx[j][k] = -16'sd32768;
        for (int df = 0; df < NOUT; df++)
            for (int j = 0; j < NIN; j++)
                for (int k = 0; k < NLEV; k++)
                    bm[df][j][k] = (df % 2 == 0) ? -16'sd32768 : 16'sd32767;
        load_all();
        run(0, "R6 run length");
        verify("R3 wide signed result");

        // R2: sparse data after large results must start from zero
        fill_random(70);
        load_all();
        run(0, "R6 run length");
        verify("R2 accumulation from zero");

        // R7/R8/R9: interference during run
        fill_random(0);
        load_all();
        run(1, "R8 run length with second start");
        verify("R7 write during busy affected result");
        rd(2'd0, 0, v);
        chk(v == bx[0][0], "R7 x unchanged after busy write", v, bx[0][0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule